// File: doc/BRIEF.md
# Double-Buffered Nibble-Addressed Converter Code Register

This block is the digital front end of a 10-bit parallel-input converter. A host drives an 8-bit data bus, a 2-bit address and three active-low strobes (chip select, write, load) that are asynchronous to the block clock. Each write fills one or two 4-bit input latches, chosen by the address. Together the three latches form a 12-bit input word: ten code bits with two sub-LSB bits underneath.

A 12-bit output latch holds the word that drives the converter. The 10-bit code output is its upper ten bits. While the load strobe is low, the output latch follows the input word. When load returns high, the output latch keeps the last word it took. A 4-bit host writes three nibbles and a byte-wide host writes low+middle and then high, and either one moves the finished word to the output with one load pulse.

An active-low clear empties the output latch at once, without a clock. A power-on reset empties every latch. A sticky flag records any write that puts a non-zero value in the sub-LSB bits.

Top module: `nibdac_front`

## Requirements
- R1: The input word is {high, middle, low} nibbles and `code_o` is bits 11..2 of the output latch. The low nibble takes `data_i[7:4]` as {D1, D0, S1, S0} (bit 7 gives D1, bit 4 gives S0). The middle nibble takes `data_i[3:0]` as D5..D2. The high nibble takes `data_i[7:4]` as D9..D6.
- R2: A write with address 2'b11 loads the high nibble, 2'b10 the middle, 2'b01 the low, and 2'b00 loads low and middle together from one bus value. The other nibbles keep their values.
- R3: A write needs `cs_n_i` and `wr_n_i` both low. A falling `wr_n_i` while `cs_n_i` is high leaves the input word unchanged.
- R4: Let `wr_n_i` first be sampled low at clock edge 1. `data_i` and `addr_i` are sampled at edge 3, and the input latch changes at edge 3. With the load strobe held low, `code_o` shows the new value after edge 4. Each falling edge of `wr_n_i` gives exactly one write.
- R5: While the synchronized load strobe is low, the output latch copies the input word on every clock. While it stays high, writes do not change `code_o`.
- R6: When `ld_n_i` rises, the output latch keeps copying until the high level has passed both synchronizer stages. After that it holds the input word it last copied.
- R7: When `clr_n_i` goes low, `code_o` becomes zero with no clock edge, whatever `cs_n_i` is. It stays zero while `clr_n_i` is low, even if the load strobe is low. The input latches keep their contents.
- R8: `rst_n` low zeroes the output latch, all three input latches and `sub_err_o`, without a clock.
- R9: `sub_err_o` goes to 1 at the edge where a low-nibble write (address 2'b00 or 2'b01) lands with `data_i[5:4]` non-zero. It stays 1 until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| data_i | input | 8 | Data bus, bits map to code bits D9..D2 |
| addr_i | input | 2 | Nibble select {A1, A0} |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| ld_n_i | input | 1 | Load strobe, active low, asynchronous |
| clr_n_i | input | 1 | Clear of the output latch, active low, asynchronous |
| code_o | output | 10 | Converter code from the output latch |
| sub_err_o | output | 1 | Sticky flag for a non-zero sub-LSB write |

## Verification
A write reaches the input latch on the third clock edge after the strobe is first sampled low. It shows at `code_o` one edge later when load is low. A load rise stops the copying two edges after it is sampled. A clear acts in the same cycle, with no edge. The bench model runs these same delays as counted sample histories and compares every clock, 2 ns after the rising edge. The directed checks sample at the falling edge: the latency check in the third and fourth cycles after the write strobe, and the clear check 1 ns after the clear falls, before any clock edge.

// File: rtl/nibdac_pkg.sv
package nibdac_pkg;

   // Number of nibble latches and sub-LSB bits in the input word
   localparam int NIB_CNT = 3;
   localparam int SUB_W   = 2;

   // Nibble slot indices inside the input word (low slot is least significant)
   localparam int SLOT_LO  = 0;
   localparam int SLOT_MID = 1;
   localparam int SLOT_HI  = 2;

   // Address codes {A1, A0}
   typedef enum logic [1:0] {
      SEL_LO_MID = 2'b00,
      SEL_LO     = 2'b01,
      SEL_MID    = 2'b10,
      SEL_HI     = 2'b11
   } nib_sel_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strobe_sync: STAGES must be at least 2");
   end

   // Stages 0..STAGES-1 form the synchronizer, and the last stage keeps one more sample for edge detection
   logic [W-1:0] pipe_q [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) pipe_q[i] <= '1;
      end else begin
         pipe_q[0] <= async_i;
         for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign sync_o = pipe_q[STAGES-1];
   assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/nib_decode.sv
module nib_decode
   import nibdac_pkg::*;
(
   input  logic               wr_evt_i,
   input  logic [1:0]         addr_i,
   output logic [NIB_CNT-1:0] en_o
);

   always_comb begin
      en_o = '0;
      if (wr_evt_i) begin
         unique case (nib_sel_e'(addr_i))
            SEL_HI:     en_o[SLOT_HI]  = 1'b1;
            SEL_MID:    en_o[SLOT_MID] = 1'b1;
            SEL_LO:     en_o[SLOT_LO]  = 1'b1;
            SEL_LO_MID: begin
               en_o[SLOT_LO]  = 1'b1;
               en_o[SLOT_MID] = 1'b1;
            end
            default:    en_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/nib_bank.sv
module nib_bank #(
   parameter int                  NIB_W     = 4,
   parameter int                  NIB_CNT   = 3,
   parameter logic [NIB_CNT-1:0]  UPPER_SRC = 3'b101
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NIB_CNT-1:0]       en_i,
   input  logic [2*NIB_W-1:0]       data_i,
   output logic [NIB_CNT*NIB_W-1:0] word_o
);

   localparam int DATA_W = 2 * NIB_W;

   if (NIB_W < 1) begin : g_bad_width
      $error("nib_bank: NIB_W must be positive");
   end

   for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
      logic [NIB_W-1:0] src;
      logic [NIB_W-1:0] nib_q;

      // Each slot takes either the upper or the lower half of the bus
      if (UPPER_SRC[g]) begin : g_up
         assign src = data_i[DATA_W-1:NIB_W];
      end else begin : g_dn
         assign src = data_i[NIB_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      nib_q <= '0;
         else if (en_i[g]) nib_q <= src;
      end

      assign word_o[g*NIB_W +: NIB_W] = nib_q;
   end

endmodule

// File: rtl/out_latch.sv
module out_latch #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_n_i,
   input  logic         upd_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] word_o
);

   // Clear and reset both act without a clock, and clear overrides any update
   always_ff @(posedge clk or negedge rst_n or negedge clr_n_i) begin
      if (!rst_n || !clr_n_i) word_o <= '0;
      else if (upd_i)         word_o <= word_i;
   end

   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |-> (word_o == '0));

endmodule

// File: rtl/nibdac_front.sv
module nibdac_front
   import nibdac_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [2*NIB_W-1:0]              data_i,
   input  logic [1:0]                      addr_i,
   input  logic                            cs_n_i,
   input  logic                            wr_n_i,
   input  logic                            ld_n_i,
   input  logic                            clr_n_i,
   output logic [NIB_CNT*NIB_W-SUB_W-1:0]  code_o,
   output logic                            sub_err_o
);

   localparam int DATA_W = 2 * NIB_W;
   localparam int WORD_W = NIB_CNT * NIB_W;
   localparam int CODE_W = WORD_W - SUB_W;

   if (NIB_W <= SUB_W) begin : g_bad_nib
      $error("nibdac_front: NIB_W must exceed the sub-LSB width");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("nibdac_front: code width must be positive");
   end

   // Strobe synchronizer, bit 0 = chip select, 1 = write, 2 = load
   logic [2:0] strb_s, strb_p;
   logic       cs_s, cs_p, wr_s, wr_p, ld_s, ld_p;

   strobe_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ld_n_i, wr_n_i, cs_n_i}),
      .sync_o  (strb_s),
      .prev_o  (strb_p)
   );

   assign {ld_s, wr_s, cs_s} = strb_s;
   assign {ld_p, wr_p, cs_p} = strb_p;

   // One write per falling edge of the write strobe, gated by chip select
   logic wr_evt;
   assign wr_evt = !wr_s && wr_p && !cs_s;

   logic [NIB_CNT-1:0] nib_en;

   nib_decode u_dec (
      .wr_evt_i (wr_evt),
      .addr_i   (addr_i),
      .en_o     (nib_en)
   );

   logic [WORD_W-1:0] in_word;

   nib_bank #(
      .NIB_W     (NIB_W),
      .NIB_CNT   (NIB_CNT),
      .UPPER_SRC (3'b101)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (nib_en),
      .data_i (data_i),
      .word_o (in_word)
   );

   // Transparent while load is low, plus one last copy as its rise passes
   logic              ld_upd;
   logic [WORD_W-1:0] out_word;
   assign ld_upd = !(ld_s && ld_p);

   out_latch #(.W(WORD_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_n_i (clr_n_i),
      .upd_i   (ld_upd),
      .word_i  (in_word),
      .word_o  (out_word)
   );

   assign code_o = out_word[WORD_W-1:SUB_W];

   // Sticky flag for sub-LSB bits written as non-zero
   logic sub_bad;
   logic sub_err_q;
   assign sub_bad = |data_i[NIB_W+SUB_W-1:NIB_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sub_err_q <= 1'b0;
      else if (nib_en[SLOT_LO] && sub_bad) sub_err_q <= 1'b1;
   end

   assign sub_err_o = sub_err_q;

   // Checks across the synchronizer, the decoder, the bank and the output latch
   assert_cs_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && cs_p) |=> $stable(in_word));

   assert_no_write_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(nib_en != '0) |=> $stable(in_word));

   assert_ld_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_s && clr_n_i) |=> (!clr_n_i || (out_word == $past(in_word))));

   assert_ld_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && ld_p && clr_n_i) |=> ($stable(out_word) || !clr_n_i));

   assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && (addr_i[1] == 1'b0) && sub_bad) |=> sub_err_o);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sub_err_o |=> sub_err_o);

endmodule

// File: tb/nibdac_front_tb_top.sv
`timescale 1ns/1ps
module nibdac_front_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] data_i;
   logic [1:0] addr_i;
   logic       cs_n_i, wr_n_i, ld_n_i, clr_n_i;
   logic [9:0] code_o;
   logic       sub_err_o;

   always #5 clk = ~clk;

   nibdac_front dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_i    (data_i),
      .addr_i    (addr_i),
      .cs_n_i    (cs_n_i),
      .wr_n_i    (wr_n_i),
      .ld_n_i    (ld_n_i),
      .clr_n_i   (clr_n_i),
      .code_o    (code_o),
      .sub_err_o (sub_err_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Behavioural reference: strobe histories as bit queues, latches as integers
   bit m_cs[$], m_wr[$], m_ld[$];
   int m_lo, m_mid, m_hi, m_out, m_err;
   bit m_evt, m_upd;
   int m_word;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cs = {1'b1, 1'b1, 1'b1};
         m_wr = {1'b1, 1'b1, 1'b1};
         m_ld = {1'b1, 1'b1, 1'b1};
         m_lo = 0; m_mid = 0; m_hi = 0; m_out = 0; m_err = 0;
      end else begin
         // index 1 = strobe two samples old, index 2 = three samples old
         m_evt  = !m_wr[1] && m_wr[2] && !m_cs[1];
         m_upd  = !(m_ld[1] && m_ld[2]);
         m_word = m_hi * 256 + m_mid * 16 + m_lo;
         if (!clr_n_i)  m_out = 0;
         else if (m_upd) m_out = m_word;
         if (m_evt) begin
            case (addr_i)
               2'b11: m_hi  = int'(data_i[7:4]);
               2'b10: m_mid = int'(data_i[3:0]);
               2'b01: begin
                  m_lo = int'(data_i[7:4]);
                  if (data_i[5:4] != 2'b00) m_err = 1;
               end
               default: begin
                  m_lo  = int'(data_i[7:4]);
                  m_mid = int'(data_i[3:0]);
                  if (data_i[5:4] != 2'b00) m_err = 1;
               end
            endcase
         end
         m_cs.push_front(cs_n_i); void'(m_cs.pop_back());
         m_wr.push_front(wr_n_i); void'(m_wr.pop_back());
         m_ld.push_front(ld_n_i); void'(m_ld.pop_back());
      end
   end

   // Per-clock comparison against the reference, covers the R4 and R5 timing
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check("R4 cycle model code", 32'(code_o), clr_n_i ? 32'(m_out >> 2) : 32'd0);
         check("R9 cycle model flag", 32'(sub_err_o), 32'(m_err));
      end
   end

   task automatic wr_nib(input logic [1:0] a, input logic [7:0] d, input logic cs);
      @(negedge clk);
      addr_i = a; data_i = d; cs_n_i = cs; wr_n_i = 1'b0;
      repeat (4) @(negedge clk);
      wr_n_i = 1'b1; cs_n_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic ld_pulse();
      @(negedge clk); ld_n_i = 1'b0;
      repeat (4) @(negedge clk); ld_n_i = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; data_i = '0; addr_i = '0;
      cs_n_i = 1'b1; wr_n_i = 1'b1; ld_n_i = 1'b1; clr_n_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 reset code", 32'(code_o), 32'd0);
      check("R8 reset flag", 32'(sub_err_o), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Load held high: two writes, then one load pulse
      wr_nib(2'b00, 8'hCA, 1'b0);
      wr_nib(2'b11, 8'hB0, 1'b0);
      check("R5 load high holds code", 32'(code_o), 32'd0);
      ld_pulse();
      check("R6 load rise captures word", 32'(code_o), 32'h2EB);

      // Write with chip select high is ignored
      wr_nib(2'b11, 8'hF0, 1'b1);
      ld_pulse();
      check("R3 chip select high ignored", 32'(code_o), 32'h2EB);

      // Transparent mode with single-nibble writes
      @(negedge clk); ld_n_i = 1'b0;
      repeat (4) @(negedge clk);
      check("R5 transparent start", 32'(code_o), 32'h2EB);
      wr_nib(2'b01, 8'h80, 1'b0);
      check("R2 low nibble only", 32'(code_o), 32'h2EA);
      wr_nib(2'b10, 8'h05, 1'b0);
      check("R2 middle nibble only", 32'(code_o), 32'h2D6);
      wr_nib(2'b11, 8'h30, 1'b0);
      check("R2 high nibble only", 32'(code_o), 32'h0D6);
      wr_nib(2'b01, 8'hC0, 1'b0);
      check("R1 D1 and D0 from bus bits 7 and 6", 32'(code_o), 32'h0D7);

      // Latency: strobe driven at falling edge N0, code due after the fourth rising edge
      @(negedge clk);
      addr_i = 2'b11; data_i = 8'h90; cs_n_i = 1'b0; wr_n_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R4 code not yet updated", 32'(code_o), 32'h0D7);
      @(negedge clk);
      check("R4 code updated on fourth edge", 32'(code_o), 32'h257);
      wr_n_i = 1'b1; cs_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 single write per strobe", 32'(code_o), 32'h257);

      // Sticky sub-LSB flag
      check("R9 flag clear before bad write", 32'(sub_err_o), 32'd0);
      wr_nib(2'b11, 8'h30, 1'b0);
      check("R9 high nibble bits do not set flag", 32'(sub_err_o), 32'd0);
      wr_nib(2'b01, 8'h10, 1'b0);
      check("R9 flag set by sub-LSB bit", 32'(sub_err_o), 32'd1);
      check("R1 sub-LSB bits below code", 32'(code_o), 32'h0D4);
      wr_nib(2'b01, 8'hC0, 1'b0);
      check("R9 flag stays set", 32'(sub_err_o), 32'd1);
      check("R1 code after clean low write", 32'(code_o), 32'h0D7);

      // Clear while load is high, with chip select low
      @(negedge clk); ld_n_i = 1'b1;
      repeat (5) @(negedge clk);
      cs_n_i = 1'b0;
      #1 clr_n_i = 1'b0;
      #1 check("R7 clear acts without clock", 32'(code_o), 32'd0);
      repeat (3) @(negedge clk);
      clr_n_i = 1'b1; cs_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check("R7 code stays zero after clear", 32'(code_o), 32'd0);
      ld_pulse();
      check("R7 input latches kept through clear", 32'(code_o), 32'h0D7);

      // Clear overrides a low load strobe
      @(negedge clk); ld_n_i = 1'b0; clr_n_i = 1'b0;
      repeat (5) @(negedge clk);
      check("R7 clear over load", 32'(code_o), 32'd0);
      clr_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check("R5 transparent reload after clear", 32'(code_o), 32'h0D7);

      // Reset in the middle of a run
      rst_n = 1'b0;
      #1 check("R8 reset code mid run", 32'(code_o), 32'd0);
      check("R8 reset flag mid run", 32'(sub_err_o), 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R8 input latches zeroed", 32'(code_o), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule